// File: doc/BRIEF.md
# Playback DMA Byte Counter

This block paces audio playback that is fed by a DMA channel. It decides when the DMA request line is raised and counts each byte the sample path accepts. When the programmed transfer length has been used up, it raises the playback interrupt. The transfer length is a 16-bit frame count. The block turns it into a byte count by shifting it left by a frame shift: 0 for 8-bit mono, 1 for 8-bit stereo or 16-bit mono, 2 for 16-bit stereo, and 3 is also accepted.

Software enables playback with one control bit. While the block is idle, that bit starts a run, clears the byte count and raises the request. A programmed-I/O mode bit blocks the start, and so does a configuration error from the format decoder. Bytes are counted only while the interrupt-enable bit is set. With that bit clear, transfers run without limit and no interrupt is raised.

On every cycle the block reports how many bytes remain before the terminal count. The DMA engine uses this figure to limit each burst. When the last byte is accepted, the block gives one-cycle set strobes for the status INT flag and the playback-interrupt flag, holds its interrupt line high, and starts counting again from zero.

Top module: `playback_dma_counter`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `dma_req`, `irq`, `set_int` and `set_pi` are 0.
- R2: From idle, a clock edge with `play_en`=1, `pio_mode`=0 and `cfg_err`=0 starts a run. From the next cycle `dma_req` is 1 and the byte count is 0, so `burst_limit` equals the full terminal count.
- R3: While `pio_mode`=1 an idle block does not start, and `dma_req` stays 0.
- R4: A clock edge with `play_en`=0 ends the run, and `dma_req` is 0 from the next cycle.
- R5: `cfg_err`=1 forces `dma_req` to 0 in the same cycle and ends the run at the next edge.
- R6: `fifo_full`=1 forces `dma_req` to 0 in the same cycle without ending the run.
- R7: The terminal count is `base_count` shifted left by `frame_shift`. When `irq_en`=1 and the byte that reaches it is accepted, `set_int`, `set_pi` and `irq` are all 1 in the next cycle.
- R8: After the terminal count is reached, the byte count restarts at 0, and the next run to the terminal count again takes the full number of bytes.
- R9: With `irq_en`=0, `burst_limit` is all ones, accepted bytes are not counted, and no interrupt is raised.
- R10: With `irq_en`=1, `burst_limit` equals the terminal count minus the bytes counted so far.
- R11: `irq` stays at 1 until a cycle with `irq_clear`=1. If a terminal hit and `irq_clear` fall on the same edge, the hit wins.
- R12: With `irq_en`=1 and a terminal count of 0, `burst_limit` is 0 and `dma_req` is held at 0.
- R13: `byte_ack` has no effect on the byte count while no run is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| play_en | input | 1 | Playback enable bit |
| pio_mode | input | 1 | Programmed-I/O mode bit; blocks a start |
| irq_en | input | 1 | Interrupt-enable bit; turns on counting against the terminal count |
| base_count | input | 16 | Programmed frame count |
| frame_shift | input | 2 | Bytes-per-frame shift |
| byte_ack | input | 1 | One byte accepted from DMA this cycle |
| fifo_full | input | 1 | Output FIFO full; withholds the request |
| cfg_err | input | 1 | Format decoder reports an invalid configuration |
| irq_clear | input | 1 | Clears the held interrupt |
| dma_req | output | 1 | DMA request |
| burst_limit | output | 19 | Bytes left before the terminal count, or all ones when unlimited |
| irq | output | 1 | Held playback interrupt |
| set_int | output | 1 | One-cycle set strobe for the status INT flag |
| set_pi | output | 1 | One-cycle set strobe for the playback-interrupt flag |

## Verification
`dma_req` reacts in the same cycle to `fifo_full`, `cfg_err` and a zero limit, and one edge later to a start or to `play_en` falling. `burst_limit`, `irq` and both strobes change at the edge that samples `byte_ack`. The bench drives every input just after a falling edge and reads the outputs just after the next falling edge. Each result is therefore read half a period after the rising edge that should produce it, and a same-cycle result is read before any edge has passed. Expected limits and hit positions are worked out from `base_count << frame_shift` over a sweep of small bases and every shift value.

// File: rtl/pbc_pkg.sv
// Package for the playback DMA byte counter.
// It holds the run-state encoding and a helper that sizes the counter width.
package pbc_pkg;

    typedef enum logic {
        RUN_IDLE   = 1'b0,
        RUN_ACTIVE = 1'b1
    } run_state_e;

    // Width of a byte count: base width plus the largest shift.
    function automatic int lim_width(input int base_w, input int shift_w);
        return base_w + (1 << shift_w) - 1;
    endfunction

endpackage

// File: rtl/pbc_run_gate.sv
// Run gate: holds the idle/active state and drives the DMA request.
// A start clears the byte count through the start output.
// Assumes all control inputs are synchronous to clk.
module pbc_run_gate
    import pbc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic play_en,
    input  logic pio_mode,
    input  logic cfg_err,
    input  logic fifo_full,
    input  logic limit_zero,
    output logic start,
    output logic running,
    output logic dma_req
);

    run_state_e state_q;

    // Start condition: idle, enabled, not programmed-I/O, configuration valid.
    always_comb start = (state_q == RUN_IDLE) && play_en && !pio_mode && !cfg_err;

    // State register: enter a run on start, leave on disable or config error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RUN_IDLE;
        end else begin
            case (state_q)
                RUN_IDLE:   if (start) state_q <= RUN_ACTIVE;
                RUN_ACTIVE: if (!play_en || cfg_err) state_q <= RUN_IDLE;
                default:    state_q <= RUN_IDLE;
            endcase
        end
    end

    // Request: active run, not blocked by an error, back-pressure or a zero limit.
    always_comb begin
        running = (state_q == RUN_ACTIVE);
        dma_req = running && !cfg_err && !fifo_full && !limit_zero;
    end

endmodule

// File: rtl/pbc_tally.sv
// Byte tally: counts accepted bytes against base_count << frame_shift.
// Gives the remaining-byte limit and a hit flag on the final byte.
// Assumes base_count and frame_shift are held steady during a run.
module pbc_tally #(
    parameter int BASE_W  = 16,
    parameter int SHIFT_W = 2,
    parameter int LIM_W   = pbc_pkg::lim_width(BASE_W, SHIFT_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               count_en,
    input  logic               irq_en,
    input  logic [BASE_W-1:0]  base_count,
    input  logic [SHIFT_W-1:0] frame_shift,
    output logic               hit,
    output logic               limit_zero,
    output logic [LIM_W-1:0]   limit
);

    localparam int PAD_W = LIM_W - BASE_W;

    logic [LIM_W-1:0] count_q;
    logic [LIM_W-1:0] terminal;
    logic [LIM_W-1:0] remain;
    logic             inc;

    // Terminal byte count, remaining bytes and the limit shown to the DMA engine.
    always_comb begin
        terminal   = {{PAD_W{1'b0}}, base_count} << frame_shift;
        remain     = terminal - count_q;
        inc        = count_en && irq_en && (remain != '0);
        hit        = inc && (remain == LIM_W'(1));
        limit_zero = irq_en && (remain == '0);
        limit      = irq_en ? remain : '1;
    end

    // Counter: cleared on start and on a terminal hit, otherwise steps once per counted byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || hit) begin
            count_q <= '0;
        end else if (inc) begin
            count_q <= count_q + LIM_W'(1);
        end
    end

endmodule

// File: rtl/pbc_irq_latch.sv
// Interrupt latch: holds irq from a terminal hit until it is cleared.
// Also gives one-cycle set strobes for the two status flags.
// A hit wins over a clear on the same edge.
module pbc_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic irq_clear,
    output logic irq,
    output logic set_int,
    output logic set_pi
);

    // Held interrupt, with the hit taking priority over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (hit) begin
            irq <= 1'b1;
        end else if (irq_clear) begin
            irq <= 1'b0;
        end
    end

    // Status set strobes: high for the cycle after a hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_int <= 1'b0;
            set_pi  <= 1'b0;
        end else begin
            set_int <= hit;
            set_pi  <= hit;
        end
    end

endmodule

// File: rtl/playback_dma_counter.sv
// Playback DMA byte counter top.
// Ties together the run gate, the byte tally and the interrupt latch.
// Assumes byte_ack is asserted only while dma_req is, or is otherwise safe to ignore.
module playback_dma_counter #(
    parameter int BASE_W  = 16,
    parameter int SHIFT_W = 2,
    parameter int LIM_W   = pbc_pkg::lim_width(BASE_W, SHIFT_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               play_en,
    input  logic               pio_mode,
    input  logic               irq_en,
    input  logic [BASE_W-1:0]  base_count,
    input  logic [SHIFT_W-1:0] frame_shift,
    input  logic               byte_ack,
    input  logic               fifo_full,
    input  logic               cfg_err,
    input  logic               irq_clear,
    output logic               dma_req,
    output logic [LIM_W-1:0]   burst_limit,
    output logic               irq,
    output logic               set_int,
    output logic               set_pi
);

    logic start;
    logic running;
    logic limit_zero;
    logic hit;
    logic count_en;

    // Bytes are counted only during an active run.
    always_comb count_en = running && byte_ack;

    pbc_run_gate i_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .play_en    (play_en),
        .pio_mode   (pio_mode),
        .cfg_err    (cfg_err),
        .fifo_full  (fifo_full),
        .limit_zero (limit_zero),
        .start      (start),
        .running    (running),
        .dma_req    (dma_req)
    );

    pbc_tally #(
        .BASE_W  (BASE_W),
        .SHIFT_W (SHIFT_W),
        .LIM_W   (LIM_W)
    ) i_tally (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (start),
        .count_en    (count_en),
        .irq_en      (irq_en),
        .base_count  (base_count),
        .frame_shift (frame_shift),
        .hit         (hit),
        .limit_zero  (limit_zero),
        .limit       (burst_limit)
    );

    pbc_irq_latch i_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .irq_clear (irq_clear),
        .irq       (irq),
        .set_int   (set_int),
        .set_pi    (set_pi)
    );

endmodule

// File: rtl/pbc_checker.sv
// Checker for playback_dma_counter, attached to the top with the bind below.
module pbc_checker #(
    parameter int BASE_W  = 16,
    parameter int SHIFT_W = 2,
    parameter int LIM_W   = pbc_pkg::lim_width(BASE_W, SHIFT_W)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               play_en,
    input logic               pio_mode,
    input logic               irq_en,
    input logic [BASE_W-1:0]  base_count,
    input logic [SHIFT_W-1:0] frame_shift,
    input logic               byte_ack,
    input logic               fifo_full,
    input logic               cfg_err,
    input logic               irq_clear,
    input logic               dma_req,
    input logic [LIM_W-1:0]   burst_limit,
    input logic               irq,
    input logic               set_int,
    input logic               set_pi
);

    // R5: a configuration error withholds the request at once
    a_r5_err_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !dma_req);

    // R6: a full FIFO withholds the request at once
    a_r6_full_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !dma_req);

    // R4: a disable edge drops the request in the next cycle
    a_r4_disable_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !play_en |=> !dma_req);

    // R7: the status strobes come with a raised interrupt
    a_r7_strobe_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        set_int |-> (irq && set_pi));

    // R11: the interrupt holds until it is cleared
    a_r11_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clear) |=> irq);

    // R12: a zero limit while counting withholds the request
    a_r12_zero_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && burst_limit == '0) |-> !dma_req);

endmodule

bind playback_dma_counter pbc_checker #(
    .BASE_W  (BASE_W),
    .SHIFT_W (SHIFT_W),
    .LIM_W   (LIM_W)
) i_pbc_checker (.*);

// File: tb/test_playback_dma_counter.sv
module test_playback_dma_counter;

    localparam int CLK_P   = 10;
    localparam int BASE_W  = 16;
    localparam int SHIFT_W = 2;
    localparam int LIM_W   = BASE_W + (1 << SHIFT_W) - 1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               play_en = 1'b0;
    logic               pio_mode = 1'b0;
    logic               irq_en = 1'b0;
    logic [BASE_W-1:0]  base_count = '0;
    logic [SHIFT_W-1:0] frame_shift = '0;
    logic               byte_ack = 1'b0;
    logic               fifo_full = 1'b0;
    logic               cfg_err = 1'b0;
    logic               irq_clear = 1'b0;
    logic               dma_req;
    logic [LIM_W-1:0]   burst_limit;
    logic               irq;
    logic               set_int;
    logic               set_pi;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_P/2) clk = ~clk;

    playback_dma_counter #(
        .BASE_W  (BASE_W),
        .SHIFT_W (SHIFT_W)
    ) i_playback_dma_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .play_en     (play_en),
        .pio_mode    (pio_mode),
        .irq_en      (irq_en),
        .base_count  (base_count),
        .frame_shift (frame_shift),
        .byte_ack    (byte_ack),
        .fifo_full   (fifo_full),
        .cfg_err     (cfg_err),
        .irq_clear   (irq_clear),
        .dma_req     (dma_req),
        .burst_limit (burst_limit),
        .irq         (irq),
        .set_int     (set_int),
        .set_pi      (set_pi)
    );

    // Advance to the next falling edge; outputs are then settled and inputs may change.
    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    endtask

    // Restart a run: one disabled edge, then one enabled edge.
    task automatic restart();
        play_en = 1'b0;
        step();
        play_en = 1'b1;
        step();
    endtask

    initial begin
        #(CLK_P * 150000);
        n_err++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        int term;
        step();
        step();
        chk(dma_req, 0, "R1 req in reset");
        chk(irq, 0, "R1 irq in reset");
        rst_n = 1'b1;
        step();
        chk({dma_req, irq, set_int, set_pi}, 0, "R1 after reset");

        // R3: programmed-I/O mode blocks the start
        play_en = 1'b1;
        pio_mode = 1'b1;
        step();
        step();
        chk(dma_req, 0, "R3 pio blocks start");
        pio_mode = 1'b0;
        irq_en = 1'b1;
        base_count = 16'd3;
        step();
        chk(dma_req, 1, "R2 start raises req");
        chk(burst_limit, 3, "R2 count cleared on start");

        // R13: bytes while idle do not count
        byte_ack = 1'b1;
        step();
        byte_ack = 1'b0;
        chk(burst_limit, 2, "R10 one byte counted");
        play_en = 1'b0;
        step();
        chk(dma_req, 0, "R4 disable drops req");
        byte_ack = 1'b1;
        step();
        step();
        byte_ack = 1'b0;
        chk(burst_limit, 2, "R13 idle bytes ignored");
        play_en = 1'b1;
        step();
        chk(burst_limit, 3, "R2 restart clears count");

        // R7 R8 R10 R11: sweep of bases and shifts
        for (int sh = 0; sh < 4; sh++) begin
            for (int b = 1; b <= 5; b++) begin
                base_count = 16'(b);
                frame_shift = 2'(sh);
                restart();
                term = b << sh;
                for (int pass = 0; pass < 2; pass++) begin
                    for (int k = 0; k < term; k++) begin
                        chk(burst_limit, 32'(term - k), "R10 remaining bytes");
                        byte_ack = 1'b1;
                        step();
                        byte_ack = 1'b0;
                        if (k < term - 1) begin
                            chk(set_int, 0, "R7 no early strobe");
                        end else begin
                            chk({set_int, set_pi, irq}, 3'b111, "R7 terminal hit");
                            chk(burst_limit, 32'(term), "R8 count restarts");
                        end
                    end
                    step();
                    chk({irq, set_int}, 2'b10, "R11 irq held, strobe gone");
                    irq_clear = 1'b1;
                    step();
                    irq_clear = 1'b0;
                    chk(irq, 0, "R11 irq cleared");
                end
            end
        end

        // R11: hit and clear on the same edge, the hit wins
        base_count = 16'd2;
        frame_shift = 2'd0;
        restart();
        byte_ack = 1'b1;
        step();
        irq_clear = 1'b1;
        step();
        byte_ack = 1'b0;
        irq_clear = 1'b0;
        chk(irq, 1, "R11 hit wins over clear");
        irq_clear = 1'b1;
        step();
        irq_clear = 1'b0;

        // R9: counting off means no limit and no interrupt
        irq_en = 1'b0;
        restart();
        chk(burst_limit, 32'h7FFFF, "R9 unlimited");
        byte_ack = 1'b1;
        for (int k = 0; k < 4; k++) step();
        byte_ack = 1'b0;
        step();
        chk({irq, set_int}, 0, "R9 no interrupt");
        irq_en = 1'b1;
        #1;
        chk(burst_limit, 2, "R9 bytes not counted");

        // R6: a full FIFO withholds the request in the same cycle
        fifo_full = 1'b1;
        #1;
        chk(dma_req, 0, "R6 full blocks req");
        fifo_full = 1'b0;
        #1;
        chk(dma_req, 1, "R6 run kept");

        // R5: a configuration error withholds the request and ends the run
        step();
        cfg_err = 1'b1;
        #1;
        chk(dma_req, 0, "R5 error blocks req");
        step();
        cfg_err = 1'b0;
        #1;
        chk(dma_req, 0, "R5 run ended");
        step();
        chk(dma_req, 1, "R5 restart after error clears");

        // R12: a zero terminal count withholds the request
        base_count = 16'd0;
        #1;
        chk(burst_limit, 0, "R12 limit zero");
        chk(dma_req, 0, "R12 req withheld");
        irq_en = 1'b0;
        #1;
        chk(dma_req, 1, "R12 req back when unlimited");

        play_en = 1'b0;
        step();
        chk(dma_req, 0, "R4 final disable");

        summary();
        $finish;
    end

endmodule